// File: doc/BRIEF.md
# Software-Held Bus Ownership Controller

This block lets software claim a shared backplane bus and keep it for as long as it likes, using two control bits in a small register. The lockout bit claims the bus and also shuts the internal transaction channel and the DMA channels off the bus. It is meant for quiescing the bus before a local reset. The keep bit claims the bus in the same way but leaves the internal channels free to use it. The block raises a bus request towards an external arbiter and watches the grant that comes back. It reports a separate acknowledge for each control bit, and it gates the request lines of the internal channels. An incoming local-reset pulse clears the lockout bit by itself, which releases the bus.

The grant input comes from outside the clock domain, so it passes through a synchronizer before any status depends on it. Each control bit drives its own ownership state machine. An acknowledge is raised only by the machine whose bit asked for the bus. A grant that arrives while that machine is not asking is ignored. The states are IDLE (bus not wanted), ASK (request raised, waiting for the synchronized grant) and HELD (ownership won for this bit). The transitions are: IDLE to ASK when the control bit is seen set; ASK to HELD when the synchronized grant is seen high; ASK to IDLE when the bit is cleared before the grant arrives; HELD to IDLE when the bit is cleared or the synchronized grant falls.

Top module: `bus_hold_arb`

## Requirements
- R1: After reset both control bits and both acknowledges read 0, `bus_req` is 0 and every `chan_go` line is 0.
- R2: A write with `wr_en` stores `wr_data[0]` as the keep bit and `wr_data[1]` as the lockout bit. `status` reads {lockout acknowledge, lockout bit, keep acknowledge, keep bit} on bits 3..0, and the stored bits appear there on the cycle after the write edge.
- R3: One clock edge after a control bit is stored, its state machine enters ASK and `bus_req` is 1. `bus_req` is 1 whenever either machine is in ASK or HELD.
- R4: The grant passes two synchronizer flops. A grant that is high before edge k moves an asking machine to HELD at edge k+2, where its acknowledge is set.
- R5: An acknowledge and the bus request behind it drop at the edge after their control bit is cleared. If the other machine is idle, `bus_req` falls on that same edge.
- R6: If the synchronized grant falls while a machine is in HELD, the acknowledge clears at the next edge. The machine returns to ASK while its bit stays set.
- R7: While the lockout bit is set every `chan_go` line is 0. Otherwise `chan_go` equals `chan_req`. The keep bit never gates the channels.
- R8: A `local_rst` pulse clears the lockout bit at the next edge and takes priority over a write that sets the lockout bit in the same cycle. The keep bit is not affected.
- R9: An acknowledge is set only by its own request. A grant seen while a machine is idle, or won for the other bit, leaves that machine's acknowledge at 0.
- R10: With both bits set, the channels stay locked out and each acknowledge follows only its own bit and the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 2 | Write data: bit 0 keep request, bit 1 lockout request |
| status | output | 4 | {lockout ack, lockout bit, keep ack, keep bit} |
| local_rst | input | 1 | Incoming local-reset pulse, clears the lockout bit |
| bus_req | output | 1 | Bus request to the external arbiter |
| bus_grant | input | 1 | Grant from the external arbiter, asynchronous |
| chan_req | input | NCH | Bus requests from the internal channels |
| chan_go | output | NCH | Channel requests after lockout gating |

## Verification
The bench drives the block against an arbiter model that answers a request after a random delay of zero to four cycles, and compares every output with a behavioural model on every clock. A keep-only run shows that the channels are not gated. A lockout-only run shows the gating and shows that the keep acknowledge stays low while the grant is held. A run with both bits set tells apart an acknowledge that follows its own bit from one that follows the grant alone. A grant forced high with no request, a grant dropped during HELD, and a local reset that collides with a write isolate the idle-grant rejection, the loss of ownership and the priority of the reset. A random mix of writes, resets and channel requests then runs through every state and transition.

// File: rtl/bha_pkg.sv
package bha_pkg;
    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_ASK  = 2'd1,
        OWN_HELD = 2'd2
    } own_state_t;

    localparam int unsigned KEEP_IDX = 0;
    localparam int unsigned LOCK_IDX = 1;
    localparam int unsigned NREQ     = 2;
endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
    import bha_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_bit,
    input  logic gnt_s,
    output logic ack,
    output logic want
);
    own_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            OWN_IDLE: if (req_bit) state_nx = OWN_ASK;
            OWN_ASK: begin
                if (!req_bit)   state_nx = OWN_IDLE;
                else if (gnt_s) state_nx = OWN_HELD;
            end
            OWN_HELD: if (!req_bit || !gnt_s) state_nx = OWN_IDLE;
            default:  state_nx = OWN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OWN_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        ack  = 1'b0;
        want = 1'b0;
        unique case (state)
            OWN_IDLE: ;
            OWN_ASK:  want = 1'b1;
            OWN_HELD: begin ack = 1'b1; want = 1'b1; end
            default:  ;
        endcase
    end

    // R9
    ack_own_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(req_bit) && $past(gnt_s));

    // R5
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_bit |=> !ack);

    // R6
    grant_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !gnt_s) |=> !ack);
endmodule

// File: rtl/bha_gate.sv
module bha_gate #(
    parameter int unsigned NCH = 4
) (
    input  logic           lock,
    input  logic [NCH-1:0] chan_req,
    output logic [NCH-1:0] chan_go
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign chan_go[i] = chan_req[i] & ~lock;
    end
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb
    import bha_pkg::*;
#(
    parameter int unsigned NCH         = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_data,
    output logic [3:0]     status,
    input  logic           local_rst,
    output logic           bus_req,
    input  logic           bus_grant,
    input  logic [NCH-1:0] chan_req,
    output logic [NCH-1:0] chan_go
);
    logic [NREQ-1:0] req_q;
    logic [NREQ-1:0] ack;
    logic [NREQ-1:0] want;
    logic            gnt_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            if (wr_en) req_q[KEEP_IDX] <= wr_data[KEEP_IDX];
            if (local_rst)  req_q[LOCK_IDX] <= 1'b0;
            else if (wr_en) req_q[LOCK_IDX] <= wr_data[LOCK_IDX];
        end
    end

    bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (bus_grant),
        .q     (gnt_s)
    );

    for (genvar r = 0; r < NREQ; r++) begin : g_own
        bha_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_bit (req_q[r]),
            .gnt_s   (gnt_s),
            .ack     (ack[r]),
            .want    (want[r])
        );
    end

    bha_gate #(.NCH(NCH)) u_gate (
        .lock     (req_q[LOCK_IDX]),
        .chan_req (chan_req),
        .chan_go  (chan_go)
    );

    assign bus_req = |want;
    assign status  = {ack[LOCK_IDX], req_q[LOCK_IDX], ack[KEEP_IDX], req_q[KEEP_IDX]};

    // R8
    local_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        local_rst |=> !status[2]);

    // R7
    lockout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> (chan_go == '0));

    // R3
    ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] || status[3]) |-> bus_req);

    // R4
    held_from_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[3]) |-> $past(bus_req));
endmodule

// File: tb/tb_bus_hold_arb.sv
`timescale 1ns/1ps
module tb_bus_hold_arb;
    localparam int NCH = 4;

    logic           clk = 0;
    logic           rst_n = 0;
    logic           wr_en = 0;
    logic [1:0]     wr_data = 0;
    logic [3:0]     status;
    logic           local_rst = 0;
    logic           bus_req;
    logic           bus_grant = 0;
    logic [NCH-1:0] chan_req = 0;
    logic [NCH-1:0] chan_go;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bus_hold_arb #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .status(status), .local_rst(local_rst), .bus_req(bus_req),
        .bus_grant(bus_grant), .chan_req(chan_req), .chan_go(chan_go)
    );

    // arbiter model: random answer delay, or forced value
    bit force_on = 0;
    bit force_val = 0;
    int wait_cnt = 0;
    always @(negedge clk) begin
        if (force_on) bus_grant <= force_val;
        else if (!bus_req) begin
            bus_grant <= 0;
            wait_cnt  <= $urandom_range(0, 4);
        end else if (!bus_grant) begin
            if (wait_cnt == 0) bus_grant <= 1;
            else wait_cnt <= wait_cnt - 1;
        end
    end

    // behavioural reference: bits, grant history, per-request phase
    bit m_keep, m_lock;
    bit g_hist[$];
    bit m_ask[2], m_own[2];
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_keep = 0; m_lock = 0;
            g_hist = {1'b0, 1'b0};
            m_ask = '{0, 0}; m_own = '{0, 0};
        end else begin
            bit gs, bits[2];
            gs = g_hist[0];
            bits[0] = m_keep; bits[1] = m_lock;
            for (int r = 0; r < 2; r++) begin
                if (!bits[r]) begin m_ask[r] = 0; m_own[r] = 0; end
                else if (m_own[r]) begin if (!gs) m_own[r] = 0; end
                else if (m_ask[r]) begin if (gs) begin m_own[r] = 1; m_ask[r] = 0; end end
                else m_ask[r] = 1;
                if (!m_own[r] && bits[r] && !m_ask[r]) m_ask[r] = 0;
            end
            // HELD -> IDLE is a real idle cycle before asking again
            void'(g_hist.pop_front());
            g_hist.push_back(bus_grant);
            if (wr_en) m_keep = wr_data[0];
            if (local_rst) m_lock = 0;
            else if (wr_en) m_lock = wr_data[1];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk("R2 keep bit", status[0], m_keep);
            chk("R2 lockout bit", status[2], m_lock);
            chk("R4 keep ack", status[1], m_own[0]);
            chk("R4 lockout ack", status[3], m_own[1]);
            chk("R3 bus_req", bus_req, m_ask[0] | m_own[0] | m_ask[1] | m_own[1]);
            chk("R7 chan_go", chan_go, m_lock ? '0 : chan_req);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] d);
        @(negedge clk); wr_en = 1; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic wait_ack(input int bitpos, input string req);
        int n = 0;
        while (status[bitpos] !== 1'b1 && n < 40) begin cyc(1); n++; end
        chk(req, status[bitpos], 1'b1);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(3);
        // R1 reset state
        chk("R1 status", status, 4'h0);
        chk("R1 bus_req", bus_req, 1'b0);
        chk("R1 chan_go", chan_go, '0);
        rst_n = 1;
        cyc(2);

        // R9: grant with no request leaves acks low
        force_on = 1; force_val = 1;
        cyc(6);
        chk("R9 idle grant", {status[3], status[1]}, 2'b00);
        force_val = 0; cyc(4); force_on = 0;

        // keep only: channels pass
        chan_req = 4'b1011;
        wr(2'b01);
        chk("R2 keep stored", status, 4'b0001);
        chk("R7 keep no gate", chan_go, 4'b1011);
        cyc(1);
        chk("R3 bus_req after keep", bus_req, 1'b1);
        wait_ack(1, "R4 keep ack");
        chk("R9 lock ack stays low", status[3], 1'b0);
        wr(2'b00);
        cyc(1);
        chk("R5 keep ack dropped", status[1], 1'b0);
        chk("R5 bus_req dropped", bus_req, 1'b0);
        cyc(4);

        // lockout only: gating, then grant loss
        wr(2'b10);
        chk("R7 lockout gates", chan_go, 4'b0000);
        wait_ack(3, "R4 lockout ack");
        chk("R9 keep ack stays low", status[1], 1'b0);
        force_on = 1; force_val = 0;
        cyc(3);
        chk("R6 ack after grant loss", status[3], 1'b0);
        force_on = 0;
        wait_ack(3, "R6 ack regained");

        // both set
        wr(2'b11);
        chk("R10 still gated", chan_go, 4'b0000);
        wait_ack(1, "R10 keep ack");
        chk("R10 lockout ack", status[3], 1'b1);
        wr(2'b10);
        cyc(1);
        chk("R10 keep ack own bit", status[1], 1'b0);
        chk("R10 lockout ack kept", status[3], 1'b1);

        // R8 local reset beats a write, keep unaffected
        @(negedge clk); wr_en = 1; wr_data = 2'b11; local_rst = 1;
        @(negedge clk); wr_en = 0; local_rst = 0;
        chk("R8 lockout cleared", status[2], 1'b0);
        chk("R8 keep untouched", status[0], 1'b1);
        chk("R8 channels free", chan_go, chan_req);
        wr(2'b00);
        cyc(6);

        // random mix
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            wr_en = ($urandom_range(0, 7) == 0);
            wr_data = 2'($urandom_range(0, 3));
            local_rst = ($urandom_range(0, 15) == 0);
            chan_req = 4'($urandom_range(0, 15));
        end
        @(negedge clk); wr_en = 0; local_rst = 0;
        cyc(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule